// File: doc/BRIEF.md
# Programmable Interrupt Level Arbiter

This block sits between twelve peripheral interrupt request lines and a small CPU core. Software gives every request line a 2-bit priority level. It does so by writing three byte-wide, write-only level registers on a simple bus that carries an address, write data and a write strobe. Each register holds the fields of four sources. All fields reset to level 3, so every source starts out disabled.

On every clock the block looks at the pending requests and their effective levels. A request takes part only if its level is numerically lower than the 2-bit current-level input taken from the CPU's condition code register. Among the requests that take part, the one with the lowest level wins, and a tie goes to the lowest-numbered source. The result leaves through a registered output stage that is built as a two-state machine:

- `OUT_IDLE`: no request is forwarded.
- `OUT_RAISED`: the CPU request is high, together with the winning index and its level.

The machine has these transitions:

- `take` (IDLE to RAISED) when a candidate exists.
- `hold` (RAISED to RAISED) while a candidate exists. The index and level still update on every cycle.
- `drop` (RAISED to IDLE) when no candidate remains.
- `stay` (IDLE to IDLE) when there is still no candidate.

Top module: `irq_level_arbiter`

## Requirements
- R1: After reset, all level fields read as encoding 3. Even with every request line high and a current level of 3, no CPU request is raised.
- R2: The field of source n is found at bus address 0x7C + n/4, at bits 2*(n mod 4)+1 down to 2*(n mod 4). Writing that byte sets the level of exactly those four sources.
- R3: A source whose field holds encoding 3 is never forwarded, whatever the current level is.
- R4: Encoding 0 acts as level 1, the highest priority. The level output reports 1 for such a source.
- R5: A pending source is forwarded only when its effective level is numerically lower than the current-level input. A current level of 0 therefore blocks every request.
- R6: Among the forwarded candidates, the one with the numerically lowest effective level wins.
- R7: When several candidates share the best level, the lowest-numbered source wins. Its 4-bit index (0 to 11) appears on the index output.
- R8: The request, index and level outputs are registered. They reflect the request and current-level inputs, and the level registers, as they stood at the previous rising clock edge.
- R9: A write to any address other than 0x7C, 0x7D or 0x7E changes no level field.
- R10: While the CPU request is low, the index output is 0 and the level output is 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 8 | Write address on the CPU bus |
| bus_wdata_i | input | 8 | Write data byte |
| bus_we_i | input | 1 | Write strobe, one byte per cycle when high |
| req_i | input | 12 | Peripheral interrupt request lines, bit n is source n |
| cur_lvl_i | input | 2 | Current interrupt level from the CPU's condition code register |
| irq_o | output | 1 | Registered interrupt request to the CPU |
| irq_src_o | output | 4 | Index of the winning source |
| irq_lvl_o | output | 2 | Effective level of the winning source |

## Verification
The assertions assume the following about the inputs:

- The request lines and the current level are synchronous, steady around each rising edge.
- The write strobe is meaningful only at a sampled edge.

Under those assumptions, the assertions hold that any raised request points at a line that was high one edge earlier, and that its level is 1 or 2 and below the current level registered at that edge.

The bench keeps to these assumptions by driving every input on the falling edge only. It mixes seeded random requests, current levels and writes with directed cases. The random writes land on addresses from 0x7A to 0x80, so the out-of-range writes are exercised alongside the valid ones.

// File: rtl/irq_level_pkg.sv
package irq_level_pkg;

    // Width of one level field and of the current-level input
    localparam int unsigned LVL_W = 2;

    // Level value that disables a source
    localparam logic [LVL_W-1:0] LVL_OFF = '1;

    // Output stage states
    typedef enum logic {
        OUT_IDLE   = 1'b0,
        OUT_RAISED = 1'b1
    } out_state_t;

    // Encoding 0 is promoted to level 1
    function automatic logic [LVL_W-1:0] eff_level(input logic [LVL_W-1:0] raw);
        return (raw == '0) ? LVL_W'(1) : raw;
    endfunction

endpackage

// File: rtl/irq_level_regs.sv
module irq_level_regs
    import irq_level_pkg::*;
#(
    parameter int unsigned N_SRC     = 12,
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned BASE_ADDR = 32'h7C,
    localparam int unsigned PER_REG  = DATA_W / LVL_W,
    localparam int unsigned N_REGS   = (N_SRC + PER_REG - 1) / PER_REG,
    localparam int unsigned FLAT_W   = N_SRC * LVL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    input  logic              bus_we_i,
    output logic [FLAT_W-1:0] lvl_flat_o
);

    logic [N_REGS*DATA_W-1:0] regs_flat;

    for (genvar r = 0; r < N_REGS; r++) begin : g_reg
        localparam int unsigned OFS = r;
        localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(BASE_ADDR + OFS);

        logic [DATA_W-1:0] byte_q;
        logic              hit;

        assign hit = bus_we_i && (bus_addr_i == MY_ADDR);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                byte_q <= '1;
            end else if (hit) begin
                byte_q <= bus_wdata_i;
            end
        end

        assign regs_flat[r*DATA_W +: DATA_W] = byte_q;
    end

    if (N_REGS * DATA_W == FLAT_W) begin : g_exact
        assign lvl_flat_o = regs_flat;
    end else begin : g_trim
        logic [N_REGS*DATA_W-FLAT_W-1:0] spare_bits;
        assign spare_bits = regs_flat[N_REGS*DATA_W-1:FLAT_W];
        assign lvl_flat_o = regs_flat[FLAT_W-1:0];
    end

endmodule

// File: rtl/irq_level_select.sv
module irq_level_select
    import irq_level_pkg::*;
#(
    parameter int unsigned N_SRC = 12,
    localparam int unsigned IDX_W  = $clog2(N_SRC),
    localparam int unsigned FLAT_W = N_SRC * LVL_W
) (
    input  logic [FLAT_W-1:0] lvl_flat_i,
    input  logic [N_SRC-1:0]  req_i,
    input  logic [LVL_W-1:0]  cur_lvl_i,
    output logic              hit_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic [LVL_W-1:0]  lvl_o
);

    logic [LVL_W-1:0] eff [N_SRC];
    logic [N_SRC-1:0] elig;

    for (genvar n = 0; n < N_SRC; n++) begin : g_src
        assign eff[n]  = eff_level(lvl_flat_i[n*LVL_W +: LVL_W]);
        assign elig[n] = req_i[n] && (eff[n] != LVL_OFF) && (eff[n] < cur_lvl_i);
    end

    // Descending scan with <= leaves the lowest index at the best level
    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        lvl_o = LVL_OFF;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (elig[i] && (eff[i] <= lvl_o)) begin
                hit_o = 1'b1;
                idx_o = IDX_W'(i);
                lvl_o = eff[i];
            end
        end
    end

endmodule

// File: rtl/irq_level_out.sv
module irq_level_out
    import irq_level_pkg::*;
#(
    parameter int unsigned IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [LVL_W-1:0] lvl_i,
    output logic             irq_o,
    output logic [IDX_W-1:0] src_o,
    output logic [LVL_W-1:0] lvl_o
);

    out_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OUT_IDLE:   state_d = hit_i ? OUT_RAISED : OUT_IDLE;   // take / stay
            OUT_RAISED: state_d = hit_i ? OUT_RAISED : OUT_IDLE;   // hold / drop
            default:    state_d = OUT_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OUT_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_o <= '0;
            lvl_o <= LVL_OFF;
        end else if (hit_i) begin
            src_o <= idx_i;
            lvl_o <= lvl_i;
        end else begin
            src_o <= '0;
            lvl_o <= LVL_OFF;
        end
    end

    assign irq_o = (state_q == OUT_RAISED);

endmodule

// File: rtl/irq_level_arbiter.sv
module irq_level_arbiter
    import irq_level_pkg::*;
#(
    parameter int unsigned N_SRC     = 12,
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned BASE_ADDR = 32'h7C,
    localparam int unsigned IDX_W    = $clog2(N_SRC),
    localparam int unsigned FLAT_W   = N_SRC * LVL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    input  logic              bus_we_i,
    input  logic [N_SRC-1:0]  req_i,
    input  logic [LVL_W-1:0]  cur_lvl_i,
    output logic              irq_o,
    output logic [IDX_W-1:0]  irq_src_o,
    output logic [LVL_W-1:0]  irq_lvl_o
);

    logic [FLAT_W-1:0] lvl_flat;
    logic              sel_hit;
    logic [IDX_W-1:0]  sel_idx;
    logic [LVL_W-1:0]  sel_lvl;

    irq_level_regs #(
        .N_SRC     (N_SRC),
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr_i  (bus_addr_i),
        .bus_wdata_i (bus_wdata_i),
        .bus_we_i    (bus_we_i),
        .lvl_flat_o  (lvl_flat)
    );

    irq_level_select #(
        .N_SRC (N_SRC)
    ) u_select (
        .lvl_flat_i (lvl_flat),
        .req_i      (req_i),
        .cur_lvl_i  (cur_lvl_i),
        .hit_o      (sel_hit),
        .idx_o      (sel_idx),
        .lvl_o      (sel_lvl)
    );

    irq_level_out #(
        .IDX_W (IDX_W)
    ) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .hit_i (sel_hit),
        .idx_i (sel_idx),
        .lvl_i (sel_lvl),
        .irq_o (irq_o),
        .src_o (irq_src_o),
        .lvl_o (irq_lvl_o)
    );

endmodule

// File: rtl/irq_level_arbiter_chk.sv
module irq_level_arbiter_chk
    import irq_level_pkg::*;
#(
    parameter int unsigned N_SRC = 12,
    localparam int unsigned IDX_W = $clog2(N_SRC)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_SRC-1:0] req_i,
    input logic [LVL_W-1:0] cur_lvl_i,
    input logic             irq_o,
    input logic [IDX_W-1:0] irq_src_o,
    input logic [LVL_W-1:0] irq_lvl_o
);

    logic [N_SRC-1:0] req_d;
    logic [LVL_W-1:0] cur_d;

    always_ff @(posedge clk) begin
        req_d <= req_i;
        cur_d <= cur_lvl_i;
    end

    assert_src_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (irq_src_o < IDX_W'(N_SRC)) && req_d[irq_src_o]);

    assert_below_current_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (irq_lvl_o < cur_d));

    // Covers R3 (never level 3) and R4 (encoding 0 reported as 1)
    assert_level_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (irq_lvl_o == 2'd1 || irq_lvl_o == 2'd2));

    assert_idle_outputs_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o |-> (irq_src_o == '0) && (irq_lvl_o == LVL_OFF));

endmodule

bind irq_level_arbiter irq_level_arbiter_chk #(
    .N_SRC (N_SRC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (req_i),
    .cur_lvl_i (cur_lvl_i),
    .irq_o     (irq_o),
    .irq_src_o (irq_src_o),
    .irq_lvl_o (irq_lvl_o)
);

// File: tb/sim_irq_level_arbiter.sv
module sim_irq_level_arbiter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [11:0] req = '0;
    logic [1:0]  cur = 2'd3;
    logic        irq;
    logic [3:0]  src;
    logic [1:0]  lvl;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic [7:0] model_reg [3];

    always #5 clk = ~clk;

    irq_level_arbiter u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr_i  (bus_addr),
        .bus_wdata_i (bus_wdata),
        .bus_we_i    (bus_we),
        .req_i       (req),
        .cur_lvl_i   (cur),
        .irq_o       (irq),
        .irq_src_o   (src),
        .irq_lvl_o   (lvl)
    );

    // Expected {irq, src, lvl} from the requirements
    function automatic logic [6:0] expect_out(logic [11:0] r, logic [1:0] c);
        for (int want = 1; want <= 2; want++) begin
            for (int n = 0; n < 12; n++) begin
                logic [1:0] f;
                int e;
                f = model_reg[n / 4][2 * (n % 4) +: 2];
                e = (f == 2'd0) ? 1 : int'(f);
                if (r[n] && e == want && e < int'(c))
                    return {1'b1, 4'(n), 2'(want)};
            end
        end
        return {1'b0, 4'd0, 2'd3};
    endfunction

    task automatic compare(string tag, logic [6:0] exp_v);
        n_checks++;
        if ({irq, src, lvl} !== exp_v) begin
            n_fails++;
            $display("FAIL %s: got irq=%0b src=%0d lvl=%0d, expected irq=%0b src=%0d lvl=%0d",
                     tag, irq, src, lvl, exp_v[6], exp_v[5:2], exp_v[1:0]);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge
    task automatic bus_write(logic [7:0] a, logic [7:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
        if (a >= 8'h7C && a <= 8'h7E) model_reg[a - 8'h7C] = d;
    endtask

    task automatic drive_check(logic [11:0] r, logic [1:0] c, string tag);
        req = r;
        cur = c;
        @(negedge clk);
        compare(tag, expect_out(r, c));
    endtask

    initial begin
        for (int k = 0; k < 3; k++) model_reg[k] = 8'hFF;
        void'($urandom(32'd20240611));
        req = '1;
        cur = 2'd3;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1", {1'b0, 4'd0, 2'd3});
        drive_check(12'hFFF, 2'd3, "R1 R10");

        // R9: out-of-range writes of all-zero fields
        bus_write(8'h7B, 8'h00);
        bus_write(8'h7F, 8'h00);
        bus_write(8'h00, 8'h00);
        drive_check(12'hFFF, 2'd3, "R9");
        compare("R9 R10", {1'b0, 4'd0, 2'd3});

        // R2: all level 2, single source 7
        for (int k = 0; k < 3; k++) bus_write(8'h7C + 8'(k), 8'hAA);
        drive_check(12'h080, 2'd3, "R2");
        compare("R2", {1'b1, 4'd7, 2'd2});

        // R8: output holds before the edge, updates after it
        req = 12'h020;
        #1;
        compare("R8 hold", {1'b1, 4'd7, 2'd2});
        @(negedge clk);
        compare("R8 update", {1'b1, 4'd5, 2'd2});

        // R5: blocking by current level
        drive_check(12'hFFF, 2'd2, "R5 equal");
        drive_check(12'hFFF, 2'd0, "R5 zero");

        // R4 and R6: source 9 at encoding 0
        bus_write(8'h7E, 8'hA2);
        drive_check(12'h208, 2'd2, "R4 R6");
        compare("R4", {1'b1, 4'd9, 2'd1});

        // R7: tie at level 1
        for (int k = 0; k < 3; k++) bus_write(8'h7C + 8'(k), 8'h55);
        drive_check(12'h850, 2'd3, "R7");
        compare("R7", {1'b1, 4'd4, 2'd1});

        // R3: source 0 disabled
        bus_write(8'h7C, 8'h57);
        drive_check(12'h001, 2'd3, "R3");
        compare("R3", {1'b0, 4'd0, 2'd3});
        drive_check(12'h003, 2'd3, "R3 R10");

        // Random mix
        for (int it = 0; it < 600; it++) begin
            if ($urandom_range(0, 3) == 0) begin
                bus_write(8'h7A + 8'($urandom_range(0, 6)), 8'($urandom()));
            end else begin
                drive_check(12'($urandom()), 2'($urandom_range(0, 3)), "R6 R7 random");
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got no finish, expected finish before timeout");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule